// File: doc/BRIEF.md
# Multi-Channel Comparator Event Timer

This block is a register-mapped event timer for system timekeeping. A 64-bit main counter advances by one on every clock while the global run bit is set. Three comparator channels watch the low 32 bits of that counter. A channel raises its interrupt when the counter value equals its comparator. In one-shot mode the comparator stays put after a hit. In periodic mode a stored period is added to the comparator on every hit, so the channel keeps firing at a fixed interval.

Software reaches all state through a single-cycle 32-bit register port. The port has an address, a write strobe, write data and combinational read data. Besides the counter halves, the map holds a capability word, a read-only tick period in femtoseconds, a global control word, a write-one-to-clear interrupt status word, and a configuration word and comparator word for each channel. Channel 1 has no periodic mode.

To program a periodic channel, software writes its configuration word with the value-set bit. The next comparator write then loads the match value, and the write after it loads the period. When legacy routing is on, channel 0 drives the legacy system-tick line and channel 1 drives the legacy RTC line. Their normal outputs stay low while it is on.

Top module: `evt_top`

## Requirements
- R1: After reset the counter reads 0, the global control word (0x010) and the status word (0x020) read 0, every comparator reads 0xFFFFFFFF, and all interrupt outputs are low.
- R2: Bit 0 of the global control word (0x010) is the run bit. While it is 0 the counter holds its value. While it is 1 the counter grows by exactly 1 per clock.
- R3: The counter's low half reads and writes at 0x0F0 and its high half at 0x0F4. A write to either half replaces that half. A carry out of the low half increments the high half.
- R4: The word at 0x000 reads 0x00008201: bits 7:0 hold revision 1, bits 12:8 hold the channel count minus one, and bit 15 flags legacy routing support. The word at 0x004 returns the PERIOD_FS parameter and ignores writes.
- R5: While the counter runs, a channel with its interrupt enable set (config bit 2) sets its status bit on the clock after the counter low half equals its comparator. In one-shot mode the comparator keeps its value, so a comparator value the counter has already passed does not fire again within the run.
- R6: Configuration bit 3 selects periodic mode and bit 6 is value-set. After a config write with bit 6 set on a periodic-capable channel, the next comparator write loads the match value and the following one loads the period. Each later hit adds the period to the comparator.
- R7: Channel 1 is not periodic-capable. Its bit 3 and its capability flag (config bit 4) read 0, and a second comparator write simply replaces its comparator. Channels 0 and 2 read bit 4 as 1.
- R8: Writing ones to the status word (0x020) clears those bits and leaves the others alone. A hit in the same cycle as its clear leaves the bit set.
- R9: Each channel interrupt equals its status bit AND its interrupt enable. When global control bit 1 (legacy) is set, channel 0's interrupt drives legacy_tick_irq and channel 1's drives legacy_rtc_irq, and chan_irq[1:0] are held low.
- R10: A channel whose interrupt enable is clear does not set its status bit on a hit.
- R11: Channel n's config word is at 0x100+0x20n and its comparator at 0x108+0x20n. The config word reads bits 2, 3 and 13:9 (route) as last written, bit 8 (32-bit mode) as 1, and bit 6 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one counter tick per cycle when running |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| chan_irq | output | NUM_CH | Per-channel interrupt lines |
| legacy_tick_irq | output | 1 | Legacy system-tick line (channel 0 under legacy routing) |
| legacy_rtc_irq | output | 1 | Legacy RTC line (channel 1 under legacy routing) |

## Verification
A register write lands at the clock edge it is presented on, and its effect is readable in the cycle right after that edge. A counter value equal to a comparator sets the status bit and the interrupt output one edge later, which is the same edge where the counter has moved one step past the match. A periodic comparator is advanced at that same edge. The reference model applies each edge's inputs to its own state at that edge. The outputs are compared a quarter period after every edge. Directed reads sample one time unit after the falling edge that presents the address, so they see only state settled by earlier edges.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int          WORD_W        = 32;
    localparam int          ROUTE_W       = 5;
    localparam logic [11:0] OFF_CAP       = 12'h000;
    localparam logic [11:0] OFF_PERIOD    = 12'h004;
    localparam logic [11:0] OFF_GCFG      = 12'h010;
    localparam logic [11:0] OFF_STATUS    = 12'h020;
    localparam logic [11:0] OFF_CNT_LO    = 12'h0F0;
    localparam logic [11:0] OFF_CNT_HI    = 12'h0F4;
    localparam logic [11:0] OFF_CH_BASE   = 12'h100;
    localparam logic [11:0] OFF_CH_STRIDE = 12'h020;
    localparam logic [11:0] OFF_CH_CMP    = 12'h008;

    // channel config bit positions
    localparam int CFG_IEN  = 2;
    localparam int CFG_PER  = 3;
    localparam int CFG_VSET = 6;
    localparam int CFG_RT   = 9;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_VALUE  = 2'd1,
        SEQ_PERIOD = 2'd2
    } seq_e;

    typedef struct packed {
        logic [WORD_W-1:0]  cmp;
        logic [WORD_W-1:0]  period;
        logic               ien;
        logic               per;
        logic [ROUTE_W-1:0] route;
        seq_e               seq;
    } chan_t;

    typedef struct packed {
        logic run;
        logic legacy;
    } gcfg_t;
endpackage

// File: rtl/evt_counter.sv
module evt_counter
    import evt_pkg::*;
#(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wdata,
    output logic [2*HALF_W-1:0] count
);
    localparam int CNT_W = 2 * HALF_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (wr_lo) begin
            cnt_d.cnt[HALF_W-1:0] = wdata;
        end else if (wr_hi) begin
            cnt_d.cnt[CNT_W-1:HALF_W] = wdata;
        end else if (run) begin
            cnt_d.cnt = cnt_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q.cnt;
endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_pkg::*;
#(
    parameter bit PER_OK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [WORD_W-1:0] cnt_lo,
    input  logic              cfg_wr,
    input  logic              cmp_wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] cfg_rd,
    output logic [WORD_W-1:0] cmp_rd,
    output logic              ien,
    output logic              fire
);
    chan_t ch_d, ch_q;
    logic  hit;

    assign hit  = run && (cnt_lo == ch_q.cmp);
    assign fire = hit && ch_q.ien;

    always_comb begin
        ch_d = ch_q;
        if (hit && ch_q.per) begin
            ch_d.cmp = ch_q.cmp + ch_q.period;
        end
        if (cfg_wr) begin
            ch_d.ien   = wdata[CFG_IEN];
            ch_d.per   = PER_OK ? wdata[CFG_PER] : 1'b0;
            ch_d.route = wdata[CFG_RT +: ROUTE_W];
            if (PER_OK && wdata[CFG_VSET]) begin
                ch_d.seq = SEQ_VALUE;
            end
        end
        if (cmp_wr) begin
            case (ch_q.seq)
                SEQ_VALUE: begin
                    ch_d.cmp = wdata;
                    ch_d.seq = SEQ_PERIOD;
                end
                SEQ_PERIOD: begin
                    ch_d.period = wdata;
                    ch_d.seq    = SEQ_IDLE;
                end
                default: ch_d.cmp = wdata;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q.cmp    <= '1;
            ch_q.period <= '0;
            ch_q.ien    <= 1'b0;
            ch_q.per    <= 1'b0;
            ch_q.route  <= '0;
            ch_q.seq    <= SEQ_IDLE;
        end else begin
            ch_q <= ch_d;
        end
    end

    // bit 8 reports fixed 32-bit compare, bit 4 reports periodic capability
    assign cfg_rd = {18'b0, ch_q.route, 1'b1, 3'b000, PER_OK, ch_q.per, ch_q.ien, 2'b00};
    assign cmp_rd = ch_q.cmp;
    assign ien    = ch_q.ien;
endmodule

// File: rtl/evt_status.sv
module evt_status #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fire,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] status
);
    typedef struct packed {
        logic [N-1:0] bits;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_wr) begin
            st_d.bits = st_q.bits & ~clr_mask;
        end
        st_d.bits = st_d.bits | fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.bits;
endmodule

// File: rtl/evt_top.sv
module evt_top
    import evt_pkg::*;
#(
    parameter int              NUM_CH    = 3,
    parameter logic [31:0]     PERIOD_FS = 32'd69841279,
    parameter logic [NUM_CH-1:0] PER_MASK = 3'b101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NUM_CH-1:0] chan_irq,
    output logic              legacy_tick_irq,
    output logic              legacy_rtc_irq
);
    localparam logic [4:0]  CH_FIELD = 5'(NUM_CH - 1);
    localparam logic [31:0] CAP_WORD = {16'h0000, 1'b1, 2'b00, CH_FIELD, 8'h01};

    gcfg_t gcfg_d, gcfg_q;

    logic              wr_gcfg, wr_stat, wr_cnt_lo, wr_cnt_hi;
    logic [63:0]       count;
    logic [NUM_CH-1:0] status, ch_ien, ch_fire, raw_irq;
    logic [WORD_W-1:0] ch_cfg_rd [NUM_CH];
    logic [WORD_W-1:0] ch_cmp_rd [NUM_CH];

    assign wr_gcfg   = reg_wr && (reg_addr == OFF_GCFG);
    assign wr_stat   = reg_wr && (reg_addr == OFF_STATUS);
    assign wr_cnt_lo = reg_wr && (reg_addr == OFF_CNT_LO);
    assign wr_cnt_hi = reg_wr && (reg_addr == OFF_CNT_HI);

    always_comb begin
        gcfg_d = gcfg_q;
        if (wr_gcfg) begin
            gcfg_d.run    = reg_wdata[0];
            gcfg_d.legacy = reg_wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gcfg_q <= '0;
        else        gcfg_q <= gcfg_d;
    end

    evt_counter #(.HALF_W(WORD_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (gcfg_q.run),
        .wr_lo (wr_cnt_lo),
        .wr_hi (wr_cnt_hi),
        .wdata (reg_wdata),
        .count (count)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [11:0] A_CFG = OFF_CH_BASE + 12'(g) * OFF_CH_STRIDE;
        localparam logic [11:0] A_CMP = A_CFG + OFF_CH_CMP;

        evt_channel #(.PER_OK(PER_MASK[g])) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (gcfg_q.run),
            .cnt_lo (count[WORD_W-1:0]),
            .cfg_wr (reg_wr && (reg_addr == A_CFG)),
            .cmp_wr (reg_wr && (reg_addr == A_CMP)),
            .wdata  (reg_wdata),
            .cfg_rd (ch_cfg_rd[g]),
            .cmp_rd (ch_cmp_rd[g]),
            .ien    (ch_ien[g]),
            .fire   (ch_fire[g])
        );
    end

    evt_status #(.N(NUM_CH)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (ch_fire),
        .clr_wr   (wr_stat),
        .clr_mask (reg_wdata[NUM_CH-1:0]),
        .status   (status)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_CAP:    reg_rdata = CAP_WORD;
            OFF_PERIOD: reg_rdata = PERIOD_FS;
            OFF_GCFG:   reg_rdata = {30'b0, gcfg_q.legacy, gcfg_q.run};
            OFF_STATUS: reg_rdata = 32'(status);
            OFF_CNT_LO: reg_rdata = count[31:0];
            OFF_CNT_HI: reg_rdata = count[63:32];
            default:    reg_rdata = '0;
        endcase
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_addr == OFF_CH_BASE + 12'(i) * OFF_CH_STRIDE) begin
                reg_rdata = ch_cfg_rd[i];
            end
            if (reg_addr == OFF_CH_BASE + 12'(i) * OFF_CH_STRIDE + OFF_CH_CMP) begin
                reg_rdata = ch_cmp_rd[i];
            end
        end
    end

    assign raw_irq = status & ch_ien;

    always_comb begin
        chan_irq        = raw_irq;
        legacy_tick_irq = 1'b0;
        legacy_rtc_irq  = 1'b0;
        if (gcfg_q.legacy) begin
            chan_irq[1:0]   = 2'b00;
            legacy_tick_irq = raw_irq[0];
            legacy_rtc_irq  = raw_irq[1];
        end
    end
endmodule

// File: rtl/evt_checker.sv
module evt_checker #(
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         cnt_wr,
    input logic [63:0]  count,
    input logic [N-1:0] status,
    input logic [N-1:0] fire,
    input logic [N-1:0] chan_irq,
    input logic         legacy,
    input logic         stat_clr,
    input logic [31:0]  wdata
);
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(count));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_wr) |=> (count == $past(count) + 64'd1));

    assert_status_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(fire)) == '0));

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> ((status & $past(wdata[N-1:0] & ~fire)) == '0));

    assert_irq_needs_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((chan_irq & ~status) == '0));

    assert_legacy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        legacy |-> (chan_irq[1:0] == 2'b00));
endmodule

bind evt_top evt_checker #(.N(NUM_CH)) u_evt_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (gcfg_q.run),
    .cnt_wr   (wr_cnt_lo || wr_cnt_hi),
    .count    (count),
    .status   (status),
    .fire     (ch_fire),
    .chan_irq (chan_irq),
    .legacy   (gcfg_q.legacy),
    .stat_clr (wr_stat),
    .wdata    (reg_wdata)
);

// File: tb/test_evt_top.sv
module test_evt_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] PER_FS = 32'd69841279;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  chan_irq;
    logic        leg_tick, leg_rtc;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_top i_evt_top (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
        .reg_rdata(rdata), .chan_irq(chan_irq),
        .legacy_tick_irq(leg_tick), .legacy_rtc_irq(leg_rtc)
    );

    // behavioural reference state
    logic [63:0] m_cnt;
    logic [31:0] m_cmp [3];
    logic [31:0] m_per [3];
    bit          m_ien [3];
    bit          m_pmode [3];
    logic [4:0]  m_rt [3];
    int          m_stage [3];
    logic [2:0]  m_stat;
    bit          m_run, m_leg;

    function automatic logic [31:0] m_read(input logic [11:0] a);
        logic [31:0] v;
        v = 32'h0;
        if (a == 12'h000) v = 32'h0000_8201;
        if (a == 12'h004) v = PER_FS;
        if (a == 12'h010) v = {30'b0, m_leg, m_run};
        if (a == 12'h020) v = {29'b0, m_stat};
        if (a == 12'h0F0) v = m_cnt[31:0];
        if (a == 12'h0F4) v = m_cnt[63:32];
        for (int c = 0; c < 3; c++) begin
            if (a == 12'h100 + 12'(c) * 12'h020)
                v = (32'(m_rt[c]) << 9) | 32'h100 | ((c != 1) ? 32'h10 : 32'h0)
                    | (m_pmode[c] ? 32'h8 : 32'h0) | (m_ien[c] ? 32'h4 : 32'h0);
            if (a == 12'h108 + 12'(c) * 12'h020) v = m_cmp[c];
        end
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_stat = 0; m_run = 0; m_leg = 0;
            for (int c = 0; c < 3; c++) begin
                m_cmp[c] = 32'hFFFF_FFFF; m_per[c] = 0; m_ien[c] = 0;
                m_pmode[c] = 0; m_rt[c] = 0; m_stage[c] = 0;
            end
        end else begin
            bit          hit [3];
            logic [2:0]  nstat;
            logic [31:0] ncmp;
            for (int c = 0; c < 3; c++) hit[c] = m_run && (m_cnt[31:0] == m_cmp[c]);
            nstat = m_stat;
            if (wr && addr == 12'h020) nstat = nstat & ~wdata[2:0];
            for (int c = 0; c < 3; c++) if (hit[c] && m_ien[c]) nstat[c] = 1'b1;
            for (int c = 0; c < 3; c++) begin
                bit cap;
                cap  = (c != 1);
                ncmp = m_cmp[c];
                if (hit[c] && m_pmode[c]) ncmp = ncmp + m_per[c];
                if (wr && addr == 12'h100 + 12'(c) * 12'h020) begin
                    m_ien[c]   = wdata[2];
                    m_pmode[c] = cap && wdata[3];
                    m_rt[c]    = wdata[13:9];
                    if (cap && wdata[6]) m_stage[c] = 1;
                end
                if (wr && addr == 12'h108 + 12'(c) * 12'h020) begin
                    if (m_stage[c] == 1) begin ncmp = wdata; m_stage[c] = 2; end
                    else if (m_stage[c] == 2) begin m_per[c] = wdata; m_stage[c] = 0; end
                    else ncmp = wdata;
                end
                m_cmp[c] = ncmp;
            end
            if (wr && addr == 12'h0F0) m_cnt[31:0] = wdata;
            else if (wr && addr == 12'h0F4) m_cnt[63:32] = wdata;
            else if (m_run) m_cnt = m_cnt + 64'd1;
            m_stat = nstat;
            if (wr && addr == 12'h010) begin m_run = wdata[0]; m_leg = wdata[1]; end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, a quarter period after each edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n) begin
            logic [2:0] raw, exp_irq;
            raw = m_stat & {m_ien[2], m_ien[1], m_ien[0]};
            exp_irq = m_leg ? {raw[2], 2'b00} : raw;
            check("R3/R11 model rdata", rdata, m_read(addr));
            check("R9 model chan_irq", {29'b0, chan_irq}, {29'b0, exp_irq});
            check("R9 model legacy lines", {30'b0, leg_tick, leg_rtc},
                  {30'b0, m_leg & raw[0], m_leg & raw[1]});
        end
    end

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wr = 1'b1; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); addr = a; wr = 1'b0; #1;
        check(tag, rdata, exp);
    endtask

    task automatic get_read(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk); addr = a; wr = 1'b0; #1;
        v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v, expc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        do_read(12'h0F0, 32'h0, "R1 counter lo");
        do_read(12'h010, 32'h0, "R1 gcfg");
        do_read(12'h020, 32'h0, "R1 status");
        do_read(12'h128, 32'hFFFF_FFFF, "R1 comparator ch1");
        check("R1 irq outputs", {29'b0, chan_irq}, 32'h0);

        // R4 capability and period
        do_read(12'h000, 32'h0000_8201, "R4 capability");
        do_write(12'h004, 32'h1234_5678);
        do_read(12'h004, PER_FS, "R4 period read-only");

        // R2 hold and step
        idle(5);
        do_read(12'h0F0, 32'h0, "R2 hold while stopped");
        do_write(12'h010, 32'h1);
        get_read(12'h0F0, v);
        do_read(12'h0F0, v + 32'd1, "R2 one step per clock");
        do_write(12'h010, 32'h0);
        get_read(12'h0F0, v);
        idle(5);
        do_read(12'h0F0, v, "R2 stopped counter holds");

        // R3 carry into high half
        do_write(12'h0F0, 32'hFFFF_FFFE);
        do_write(12'h0F4, 32'h5);
        do_write(12'h010, 32'h1);
        idle(6);
        do_write(12'h010, 32'h0);
        do_read(12'h0F4, 32'h6, "R3 carry into high half");
        do_write(12'h0F0, 32'h0);
        do_write(12'h0F4, 32'h0);
        do_read(12'h0F4, 32'h0, "R3 high half cleared");

        // R5 one-shot on channel 0
        do_write(12'h100, 32'h4);
        do_write(12'h108, 32'd20);
        do_write(12'h010, 32'h1);
        idle(40);
        do_read(12'h020, 32'h1, "R5 one-shot status");
        check("R9 chan_irq follows status", {29'b0, chan_irq}, 32'h1);
        do_read(12'h108, 32'd20, "R5 comparator unchanged");
        do_write(12'h020, 32'h1);
        idle(30);
        do_read(12'h020, 32'h0, "R5 fires only once");

        // R10 match without interrupt enable on channel 2
        get_read(12'h0F0, v);
        do_write(12'h148, v + 32'd12);
        idle(30);
        do_read(12'h020, 32'h0, "R10 no status without enable");

        // R5 already-passed comparator does not fire
        do_write(12'h140, 32'h4);
        do_write(12'h148, 32'd5);
        idle(30);
        do_read(12'h020, 32'h0, "R5 passed value stays silent");

        // R6 periodic two-write sequence on channel 2
        do_write(12'h010, 32'h0);
        do_write(12'h0F0, 32'h0);
        do_write(12'h140, 32'h4C);
        do_write(12'h148, 32'd10);
        do_write(12'h148, 32'd16);
        do_read(12'h148, 32'd10, "R6 first write sets match value");
        do_write(12'h010, 32'h1);
        idle(35);
        do_write(12'h010, 32'h0);
        get_read(12'h0F0, v);
        expc = 32'd10;
        while (expc < v) expc = expc + 32'd16;
        do_read(12'h148, expc, "R6 comparator advanced by period");
        do_read(12'h020, 32'h5, "R6 periodic status");

        // R7 channel 1 has no periodic mode
        do_write(12'h120, 32'h4C);
        do_read(12'h120, 32'h104, "R7 ch1 periodic bits read 0");
        do_read(12'h100, 32'h114, "R7 ch0 reports periodic capability");
        do_write(12'h020, 32'h7);
        do_write(12'h0F0, 32'h0);
        do_write(12'h128, 32'd5);
        do_write(12'h128, 32'd100);
        do_read(12'h128, 32'd100, "R7 second write replaces comparator");
        do_write(12'h010, 32'h1);
        idle(110);
        do_write(12'h010, 32'h0);
        do_read(12'h128, 32'd100, "R7 ch1 one-shot comparator kept");
        do_read(12'h020, 32'h7, "R7 all channels hit");

        // R9 legacy routing
        check("R9 normal routing", {29'b0, chan_irq}, 32'h7);
        do_write(12'h010, 32'h2);
        #1;
        check("R9 legacy chan_irq", {29'b0, chan_irq}, 32'h4);
        check("R9 legacy lines", {30'b0, leg_tick, leg_rtc}, 32'h3);

        // R8 partial clear
        do_write(12'h020, 32'h1);
        do_read(12'h020, 32'h6, "R8 only written bits clear");
        check("R9 legacy tick drops", {30'b0, leg_tick, leg_rtc}, 32'h1);

        // R11 config readback
        do_write(12'h100, 32'h0E44);
        do_read(12'h100, 32'h0F14, "R11 config readback");

        idle(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule